// File: doc/BRIEF.md
# Supply Reset Sequencer

This block is a digital reset supervisor for a chip's supply. It sees five comparator indications as plain digital flags: supply above the upper and below the lower power-on threshold, supply above the upper and below the lower level-0 brownout threshold, and supply below the currently selected early-warning brownout level. Every flag is synchronized and debounced, and the filtered flags drive a three-state sequencer. The states are: held in power-on reset, held in brownout reset, and running. From the state the block makes the enables for the reference and brownout detector, the enable for the power management unit, a boot-continue release, and a reset for a real-time-clock domain.

Software can pick a brownout early-warning level from 0 to 3. The block feeds the active level back to the comparator through `borLevel`, which also serves as the readback. When level 1, 2 or 3 is active and the supply falls below it while running, the block sets a sticky interrupt flag and drops the active level to 0 by itself. After that, only a fall below the level-0 threshold puts the chip into brownout reset. The interrupt flag stays set until a write-one-to-clear pulse. Power-on reset clears it.

Top module: `supply_reset_seq`

## Requirements
- R1: After `arstN` is released the block is in power-on reset: `refEn`, `pmuEn`, `bootRelease` and `irqFlag` are 0, `rtcRst` is 1 and `borLevel` is 0.
- R2: A flag change takes effect only after it has been stable at the synchronizer output for DEBOUNCE cycles. A rising `porRiseIn` moves the state on the (DEBOUNCE+3)-th clock edge after it is applied. A pulse shorter than DEBOUNCE cycles has no effect.
- R3: In power-on reset, a filtered `porRiseIn` of 1 moves the block to brownout reset, which raises `refEn` while `pmuEn` stays 0.
- R4: In brownout reset, a filtered `bor0RiseIn` of 1 moves the block to running, which raises `pmuEn` and `bootRelease`.
- R5: While running, a filtered `bor0FallIn` of 1 moves the block back to brownout reset: `pmuEn` and `bootRelease` fall and `refEn` stays 1.
- R6: A filtered `porFallIn` of 1 forces power-on reset from every state, which drops `refEn`. Power-on reset never leads straight to running.
- R7: A `levelWr` pulse copies `levelSel` into `borLevel` only while running. Outside running it leaves `borLevel` unchanged.
- R8: While running with `borLevel` at 1, 2 or 3, a filtered `borWarnIn` of 1 sets `irqFlag` and returns `borLevel` to 0 on the next edge.
- R9: With `borLevel` at 0, `borWarnIn` has no effect on `irqFlag`.
- R10: `irqFlag` stays set until an `irqClr` pulse clears it.
- R11: Entering power-on reset clears `irqFlag` and resets `borLevel` to 0.
- R12: `rtcRst` is 1 whenever the block is not running or `bootRstReq` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| arstN | input | 1 | Asynchronous active-low reset of the digital logic |
| porRiseIn | input | 1 | Supply above upper power-on threshold |
| porFallIn | input | 1 | Supply below lower power-on threshold |
| bor0RiseIn | input | 1 | Supply above upper level-0 brownout threshold |
| bor0FallIn | input | 1 | Supply below lower level-0 brownout threshold |
| borWarnIn | input | 1 | Supply below the active early-warning level |
| bootRstReq | input | 1 | Boot reset request, forwarded to the RTC reset |
| levelSel | input | LVL_W | Requested brownout early-warning level |
| levelWr | input | 1 | Write strobe for `levelSel` |
| irqClr | input | 1 | Write-one-to-clear for `irqFlag` |
| refEn | output | 1 | Reference and brownout detector enable |
| pmuEn | output | 1 | Power management unit enable |
| bootRelease | output | 1 | Boot sequence may continue |
| rtcRst | output | 1 | Reset for the real-time-clock domain |
| borLevel | output | LVL_W | Active early-warning level (readback and comparator select) |
| irqFlag | output | 1 | Sticky early-warning interrupt |

## Verification
The hardest case to reach is the automatic fallback. The block has to be running with a nonzero level written, and then the warning flag has to pass the filter. The bench walks the supply flags through the power-on and brownout thresholds into running and writes each of the levels 1 to 3 in turn. For each level it holds the warning flag and samples one edge before and one edge after the fallback. It sweeps glitch lengths from 1 to DEBOUNCE-1 to show that they are rejected. It measures the exact edge at which a stable flag first changes the state.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_POR = 2'd0,
    ST_BOR = 2'd1,
    ST_RUN = 2'd2
  } supState_t;

  typedef struct packed {
    logic holdPor;    // clear level and interrupt
    logic acceptCfg;  // level writes allowed
    logic watchWarn;  // early-warning comparator is watched
  } ctrlStrobe_t;

  localparam int NUM_FLAGS     = 5;
  localparam int FLG_POR_RISE  = 0;
  localparam int FLG_POR_FALL  = 1;
  localparam int FLG_BOR0_RISE = 2;
  localparam int FLG_BOR0_FALL = 3;
  localparam int FLG_WARN      = 4;
endpackage

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
  parameter int WIDTH    = 5,
  parameter int DEBOUNCE = 4
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] fltOut
);
  localparam int CNT_W = (DEBOUNCE > 1) ? $clog2(DEBOUNCE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE - 1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_flag
    logic syncA, syncB, dbVal;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        dbVal <= 1'b0;
        cnt   <= '0;
      end else begin
        syncA <= rawIn[g];
        syncB <= syncA;
        if (syncB == dbVal) begin
          cnt <= '0;
        end else if (cnt == CNT_LAST) begin
          dbVal <= syncB;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign fltOut[g] = dbVal;
  end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic        clk,
  input  logic        arstN,
  input  logic        porRiseDb,
  input  logic        porFallDb,
  input  logic        bor0RiseDb,
  input  logic        bor0FallDb,
  output supState_t   state,
  output ctrlStrobe_t strobe
);
  supState_t nextState;

  always_comb begin
    nextState = state;
    if (porFallDb) begin
      nextState = ST_POR;
    end else begin
      unique case (state)
        ST_POR:  if (porRiseDb)  nextState = ST_BOR;
        ST_BOR:  if (bor0RiseDb) nextState = ST_RUN;
        ST_RUN:  if (bor0FallDb) nextState = ST_BOR;
        default: nextState = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_POR;
    else        state <= nextState;
  end

  always_comb begin
    strobe.holdPor   = (state == ST_POR);
    strobe.acceptCfg = (state == ST_RUN);
    strobe.watchWarn = (state == ST_RUN);
  end
endmodule

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             arstN,
  input  ctrlStrobe_t      strobe,
  input  logic             warnDb,
  input  logic [LVL_W-1:0] levelSel,
  input  logic             levelWr,
  input  logic             irqClr,
  output logic [LVL_W-1:0] borLevel,
  output logic             irqFlag
);
  logic warnHit;
  assign warnHit = strobe.watchWarn && warnDb && (borLevel != '0);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      borLevel <= '0;
      irqFlag  <= 1'b0;
    end else if (strobe.holdPor) begin
      borLevel <= '0;
      irqFlag  <= 1'b0;
    end else begin
      if (warnHit) begin
        borLevel <= '0;
        irqFlag  <= 1'b1;
      end else begin
        if (strobe.acceptCfg && levelWr) borLevel <= levelSel;
        if (irqClr) irqFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rstseq_pkg::*;
#(
  parameter int LVL_W    = 2,
  parameter int DEBOUNCE = 4
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic             porRiseIn,
  input  logic             porFallIn,
  input  logic             bor0RiseIn,
  input  logic             bor0FallIn,
  input  logic             borWarnIn,
  input  logic             bootRstReq,
  input  logic [LVL_W-1:0] levelSel,
  input  logic             levelWr,
  input  logic             irqClr,
  output logic             refEn,
  output logic             pmuEn,
  output logic             bootRelease,
  output logic             rtcRst,
  output logic [LVL_W-1:0] borLevel,
  output logic             irqFlag
);
  logic [NUM_FLAGS-1:0] rawFlags, fltFlags;
  logic porFallDb, warnDb;
  supState_t   state;
  ctrlStrobe_t strobe;

  always_comb begin
    rawFlags                = '0;
    rawFlags[FLG_POR_RISE]  = porRiseIn;
    rawFlags[FLG_POR_FALL]  = porFallIn;
    rawFlags[FLG_BOR0_RISE] = bor0RiseIn;
    rawFlags[FLG_BOR0_FALL] = bor0FallIn;
    rawFlags[FLG_WARN]      = borWarnIn;
  end

  rstseq_filter #(.WIDTH(NUM_FLAGS), .DEBOUNCE(DEBOUNCE)) filt_i (
    .clk(clk), .arstN(arstN), .rawIn(rawFlags), .fltOut(fltFlags)
  );

  assign porFallDb = fltFlags[FLG_POR_FALL];
  assign warnDb    = fltFlags[FLG_WARN];

  rstseq_ctrl ctrl_i (
    .clk(clk), .arstN(arstN),
    .porRiseDb(fltFlags[FLG_POR_RISE]), .porFallDb(porFallDb),
    .bor0RiseDb(fltFlags[FLG_BOR0_RISE]), .bor0FallDb(fltFlags[FLG_BOR0_FALL]),
    .state(state), .strobe(strobe)
  );

  rstseq_dp #(.LVL_W(LVL_W)) dp_i (
    .clk(clk), .arstN(arstN), .strobe(strobe), .warnDb(warnDb),
    .levelSel(levelSel), .levelWr(levelWr), .irqClr(irqClr),
    .borLevel(borLevel), .irqFlag(irqFlag)
  );

  assign refEn       = (state != ST_POR);
  assign pmuEn       = (state == ST_RUN);
  assign bootRelease = (state == ST_RUN);
  assign rtcRst      = (state != ST_RUN) || bootRstReq;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             arstN,
  input logic             porFallDb,
  input logic             warnDb,
  input logic             refEn,
  input logic             pmuEn,
  input logic             bootRelease,
  input logic             rtcRst,
  input logic [LVL_W-1:0] borLevel,
  input logic             irqFlag
);
  // R4
  pmu_needs_ref_chk: assert property (@(posedge clk) disable iff (!arstN)
    pmuEn |-> refEn);

  // R12
  rtc_held_chk: assert property (@(posedge clk) disable iff (!arstN)
    !bootRelease |-> rtcRst);

  // R6
  por_entry_chk: assert property (@(posedge clk) disable iff (!arstN)
    porFallDb |=> !refEn);

  // R6
  no_skip_bor_chk: assert property (@(posedge clk) disable iff (!arstN)
    !refEn |=> !pmuEn);

  // R8
  warn_fallback_chk: assert property (@(posedge clk) disable iff (!arstN)
    (bootRelease && warnDb && borLevel != '0) |=> (borLevel == '0 && irqFlag));

  // R7
  level_frozen_chk: assert property (@(posedge clk) disable iff (!arstN)
    (refEn && !bootRelease) |=> $stable(borLevel));

  // R11
  por_clears_chk: assert property (@(posedge clk) disable iff (!arstN)
    !refEn |=> (!irqFlag && borLevel == '0));
endmodule

bind supply_reset_seq rstseq_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .arstN(arstN), .porFallDb(porFallDb), .warnDb(warnDb),
  .refEn(refEn), .pmuEn(pmuEn), .bootRelease(bootRelease), .rtcRst(rtcRst),
  .borLevel(borLevel), .irqFlag(irqFlag)
);

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb_top;
  localparam int LVL_W = 2;
  localparam int DB    = 3;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic porRiseIn = 0, porFallIn = 1, bor0RiseIn = 0, bor0FallIn = 1, borWarnIn = 0;
  logic bootRstReq = 0, levelWr = 0, irqClr = 0;
  logic [LVL_W-1:0] levelSel = '0;
  logic refEn, pmuEn, bootRelease, rtcRst, irqFlag;
  logic [LVL_W-1:0] borLevel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  supply_reset_seq #(.LVL_W(LVL_W), .DEBOUNCE(DB)) dut_i (
    .clk(clk), .arstN(arstN), .porRiseIn(porRiseIn), .porFallIn(porFallIn),
    .bor0RiseIn(bor0RiseIn), .bor0FallIn(bor0FallIn), .borWarnIn(borWarnIn),
    .bootRstReq(bootRstReq), .levelSel(levelSel), .levelWr(levelWr), .irqClr(irqClr),
    .refEn(refEn), .pmuEn(pmuEn), .bootRelease(bootRelease), .rtcRst(rtcRst),
    .borLevel(borLevel), .irqFlag(irqFlag)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input int r, input int p, input int b, input int t);
    check({req, " refEn"}, refEn, r);
    check({req, " pmuEn"}, pmuEn, p);
    check({req, " bootRelease"}, bootRelease, b);
    check({req, " rtcRst"}, rtcRst, t);
  endtask

  task automatic writeLevel(input int lvl);
    levelSel = LVL_W'(lvl);
    levelWr = 1;
    step(1);
    levelWr = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    step(2);
    arstN = 1;
    step(1);
    // R1 reset state
    outs("R1", 0, 0, 0, 1);
    check("R1 borLevel", borLevel, 0);
    check("R1 irqFlag", irqFlag, 0);

    // R2 glitches shorter than DB are rejected
    porFallIn = 0;
    step(DB + 4);
    for (int len = 1; len < DB; len++) begin
      porRiseIn = 1;
      step(len);
      porRiseIn = 0;
      step(DB + 4);
      check("R2 glitch refEn", refEn, 0);
    end

    // R2/R3 exact latency of a stable flag
    porRiseIn = 1;
    step(DB + 2);
    check("R2 before latency", refEn, 0);
    step(1);
    check("R2 at latency", refEn, 1);
    outs("R3", 1, 0, 0, 1);

    // R7 write ignored in brownout reset
    writeLevel(3);
    check("R7 write in BOR", borLevel, 0);

    // R4 to running
    bor0FallIn = 0;
    bor0RiseIn = 1;
    step(DB + 4);
    outs("R4", 1, 1, 1, 0);

    // R12 boot reset forwarded
    bootRstReq = 1;
    step(1);
    check("R12 bootRstReq rtcRst", rtcRst, 1);
    bootRstReq = 0;
    step(1);
    check("R12 released rtcRst", rtcRst, 0);

    // R9 warning ignored at level 0
    borWarnIn = 1;
    step(DB + 5);
    check("R9 irqFlag", irqFlag, 0);
    check("R9 borLevel", borLevel, 0);
    borWarnIn = 0;
    step(DB + 4);

    // R8/R10 sweep of nonzero levels
    for (int lvl = 1; lvl < (1 << LVL_W); lvl++) begin
      writeLevel(lvl);
      check("R7 write in RUN", borLevel, lvl);
      borWarnIn = 1;
      step(DB + 2);
      check("R8 level before fallback", borLevel, lvl);
      check("R8 irq before fallback", irqFlag, 0);
      step(1);
      check("R8 level after fallback", borLevel, 0);
      check("R8 irq after fallback", irqFlag, 1);
      borWarnIn = 0;
      step(DB + 6);
      check("R10 irq sticky", irqFlag, 1);
      outs("R8 still running", 1, 1, 1, 0);
      irqClr = 1;
      step(1);
      irqClr = 0;
      check("R10 irq cleared", irqFlag, 0);
    end

    // R5 back to brownout reset, level kept
    writeLevel(2);
    bor0RiseIn = 0;
    bor0FallIn = 1;
    step(DB + 4);
    outs("R5", 1, 0, 0, 1);
    writeLevel(1);
    check("R7 write ignored after R5", borLevel, 2);

    // back to running, set irq with level 2 pending again
    bor0FallIn = 0;
    bor0RiseIn = 1;
    step(DB + 4);
    outs("R4 re-entry", 1, 1, 1, 0);
    borWarnIn = 1;
    step(DB + 4);
    borWarnIn = 0;
    writeLevel(3);
    check("R11 setup irq", irqFlag, 1);
    check("R11 setup level", borLevel, 3);

    // R6/R11 power-on fall from running
    porRiseIn = 0;
    porFallIn = 1;
    step(DB + 3);
    outs("R6", 0, 0, 0, 1);
    step(1);
    check("R11 irq cleared", irqFlag, 0);
    check("R11 level cleared", borLevel, 0);

    // R6 no direct jump to running: both rise flags together
    porFallIn = 0;
    bor0FallIn = 0;
    bor0RiseIn = 1;
    porRiseIn = 1;
    step(DB + 3);
    outs("R6 via BOR", 1, 0, 0, 1);
    step(1);
    outs("R6 then RUN", 1, 1, 1, 0);

    finish();
  end
endmodule